// File: doc/BRIEF.md
# Trap Entry and Interrupt Arbiter

This block decides when a processor core leaves its normal flow for a trap. It then carries out the state update that goes with trap entry. It takes three kinds of request:

- a synchronous trap request carrying its own 8-bit trap type;
- a register-window save or restore request, which the block checks against an invalid-window mask;
- a 4-bit external interrupt level, which is compared with the processor interrupt level.

It holds the architectural state that trap entry touches:

- the current window pointer;
- the trap-enable, supervisor and previous-supervisor flags;
- the trap base register;
- the program counter pair.

When a trap is taken, the block runs a fixed four-cycle sequence. First it stores the trap type in the base register and updates the mode flags, and it rotates the window pointer down by one. Next it issues two register-file write requests that save the old PC and then the old next-PC into the new window. Last it vectors to the handler. A trap that arrives while traps are disabled does not vector: the block enters a terminal error mode, which only reset leaves.

A control load port lets the surrounding core set the whole state while the block is idle. An optional single-vector input sends every trap to one handler address: the trap type is dropped from the vector, although it is still recorded in the base register.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the window pointer is 0, trap-enable is 0, supervisor is 1, previous-supervisor is 0, the trap base register reads 0, PC is 0, next-PC is 4, and both busy and error mode are 0.
- R2: An interrupt level is taken only when it is nonzero, trap-enable is 1, and the level either equals 15 or is strictly greater than the processor interrupt level. Its trap type is 0x10 plus the level.
- R3: When several requests are present in the same idle cycle, the order of precedence is: control load, then synchronous trap request, then window save, then window restore, then interrupt. Only one of them is acted on.
- R4: A trap of any source that occurs while trap-enable is 0 sets error mode and leaves busy low. In error mode every input is ignored and all state is frozen until reset.
- R5: After entry the trap base register holds the unchanged 20-bit base in bits 31:12, the trap type in bits 11:4, and zero in bits 3:0.
- R6: After entry trap-enable is 0, previous-supervisor holds the supervisor value from before the trap, and supervisor is 1.
- R7: Entry decrements the window pointer modulo 8 (0 wraps to 7). On the following cycle a write request goes out for register 17 of the new window carrying the old PC. On the cycle after that a write request goes out for register 18 carrying the old next-PC.
- R8: After entry PC equals the trap base register and next-PC equals PC + 4. When single-vector mode is on, PC instead equals the base register with bits 11:0 cleared.
- R9: A save targets window pointer − 1 and a restore targets window pointer + 1, both modulo 8. If the target's bit in the invalid-window mask is set, the request traps with type 0x05 (save) or 0x06 (restore). Otherwise the window pointer moves to the target and no trap is taken.
- R10: Busy is high for exactly the four cycles after a trap is accepted. While busy is high, every request input, including interrupts and control loads, is ignored.
- R11: A control load in an idle cycle sets the window pointer, the three mode flags, the 20-bit base, PC and next-PC to the values on the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLevel | input | 4 | External interrupt level, 0 = none |
| pilLevel | input | 4 | Processor interrupt level (mask threshold) |
| trapReq | input | 1 | Synchronous trap request |
| trapType | input | 8 | Trap type of the synchronous request |
| winSaveReq | input | 1 | Window save request |
| winRestoreReq | input | 1 | Window restore request |
| wimMask | input | 8 | Invalid-window mask, one bit per window |
| svEnable | input | 1 | Single-vector mode enable |
| ctlWrEn | input | 1 | Control load strobe |
| ctlCwp | input | 3 | Loaded window pointer |
| ctlEt | input | 1 | Loaded trap-enable |
| ctlS | input | 1 | Loaded supervisor flag |
| ctlPs | input | 1 | Loaded previous-supervisor flag |
| ctlTbrBase | input | 20 | Loaded trap base (bits 31:12) |
| ctlPc | input | 32 | Loaded PC |
| ctlNpc | input | 32 | Loaded next-PC |
| regWrEn | output | 1 | Register-file write request |
| regWrWin | output | 3 | Window of the write |
| regWrIdx | output | 5 | Register index within the window |
| regWrData | output | 32 | Write data |
| pcOut | output | 32 | Current PC |
| npcOut | output | 32 | Current next-PC |
| tbrOut | output | 32 | Trap base register |
| cwpOut | output | 3 | Current window pointer |
| etOut | output | 1 | Trap-enable flag |
| sOut | output | 1 | Supervisor flag |
| psOut | output | 1 | Previous-supervisor flag |
| busy | output | 1 | Trap entry sequence in progress |
| errorMode | output | 1 | Error mode (trap while traps disabled) |

## Verification
The arbitration is tried with interrupt levels equal to, one above and below the mask level, with level 15 against mask 15, and with level 0. These cases separate a greater-than comparison from a greater-or-equal one and confirm that level 15 is never masked. Simultaneous synchronous, window and interrupt requests show that exactly one source wins: the window pointer moves by one, not two, and the recorded type identifies the winner. Window requests are run both with the target's mask bit clear and set, including wrap from 0 to 7 and from 7 to 0, so that a plain pointer move can be told apart from a fault trap. Random mixes of all inputs, with traps enabled and disabled, in both vector modes and with requests held high during the busy window, are compared cycle by cycle with a bench model of the state.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int TT_W  = 8;
  localparam int IDX_W = 5;

  localparam logic [TT_W-1:0]  TT_WIN_OVF  = 8'h05;
  localparam logic [TT_W-1:0]  TT_WIN_UNF  = 8'h06;
  localparam logic [TT_W-1:0]  TT_IRQ_BASE = 8'h10;
  localparam logic [IDX_W-1:0] PC_SLOT     = 5'd17;
  localparam logic [IDX_W-1:0] NPC_SLOT    = 5'd18;

  // strobes from the sequencer to the state datapath
  typedef struct packed {
    logic            ldState;
    logic            latchType;
    logic            rotate;
    logic            savePc;
    logic            saveNpc;
    logic            vector;
    logic            winSave;
    logic            winRestore;
    logic [TT_W-1:0] trapType;
  } strobe_t;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [3:0]      irqLevel,
  input  logic [3:0]      pilLevel,
  input  logic            trapReq,
  input  logic [TT_W-1:0] trapType,
  input  logic            winSaveReq,
  input  logic            winRestoreReq,
  input  logic            ctlWrEn,
  input  logic            etCur,
  input  logic            saveFault,
  input  logic            restoreFault,
  output strobe_t         strb,
  output logic            busy,
  output logic            errorMode
);
  typedef enum logic [2:0] {ST_IDLE, ST_ROT, ST_SPC, ST_SNPC, ST_VEC, ST_ERR} state_t;
  state_t st, stNext;

  logic            irqOk;
  logic            takeTrap;
  logic [TT_W-1:0] selType;

  assign irqOk = (irqLevel != 4'h0) && etCur &&
                 ((irqLevel == 4'hF) || (irqLevel > pilLevel));

  always_comb begin
    strb     = '0;
    stNext   = st;
    takeTrap = 1'b0;
    selType  = '0;
    case (st)
      ST_IDLE: begin
        if (ctlWrEn) begin
          strb.ldState = 1'b1;
        end else if (trapReq) begin
          takeTrap = 1'b1;
          selType  = trapType;
        end else if (winSaveReq) begin
          if (saveFault) begin
            takeTrap = 1'b1;
            selType  = TT_WIN_OVF;
          end else begin
            strb.winSave = 1'b1;
          end
        end else if (winRestoreReq) begin
          if (restoreFault) begin
            takeTrap = 1'b1;
            selType  = TT_WIN_UNF;
          end else begin
            strb.winRestore = 1'b1;
          end
        end else if (irqOk) begin
          takeTrap = 1'b1;
          selType  = TT_IRQ_BASE + {4'h0, irqLevel};
        end
        strb.trapType = selType;
        if (takeTrap) begin
          if (etCur) begin
            strb.latchType = 1'b1;
            stNext         = ST_ROT;
          end else begin
            stNext = ST_ERR;
          end
        end
      end
      ST_ROT:  begin strb.rotate  = 1'b1; stNext = ST_SPC;  end
      ST_SPC:  begin strb.savePc  = 1'b1; stNext = ST_SNPC; end
      ST_SNPC: begin strb.saveNpc = 1'b1; stNext = ST_VEC;  end
      ST_VEC:  begin strb.vector  = 1'b1; stNext = ST_IDLE; end
      default: stNext = ST_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign busy      = (st == ST_ROT) || (st == ST_SPC) || (st == ST_SNPC) || (st == ST_VEC);
  assign errorMode = (st == ST_ERR);

  // R4: error mode is left only through reset
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    errorMode |=> errorMode) else $error("error mode released");
endmodule

// File: rtl/trap_entry_dpath.sv
module trap_entry_dpath
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NWIN = 8,
  localparam int CWP_W  = $clog2(NWIN),
  localparam int BASE_W = XLEN - 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NWIN-1:0]   wimMask,
  input  logic              svEnable,
  input  logic [CWP_W-1:0]  ctlCwp,
  input  logic              ctlEt,
  input  logic              ctlS,
  input  logic              ctlPs,
  input  logic [BASE_W-1:0] ctlTbrBase,
  input  logic [XLEN-1:0]   ctlPc,
  input  logic [XLEN-1:0]   ctlNpc,
  output logic              saveFault,
  output logic              restoreFault,
  output logic              regWrEn,
  output logic [CWP_W-1:0]  regWrWin,
  output logic [IDX_W-1:0]  regWrIdx,
  output logic [XLEN-1:0]   regWrData,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   npcOut,
  output logic [XLEN-1:0]   tbrOut,
  output logic [CWP_W-1:0]  cwpOut,
  output logic              etOut,
  output logic              sOut,
  output logic              psOut
);
  logic [CWP_W-1:0]  cwp, cwpDn, cwpUp;
  logic              et, sup, prevSup;
  logic [BASE_W-1:0] tbrBase;
  logic [TT_W-1:0]   ttReg;
  logic [XLEN-1:0]   pc, npc, vecAddr;

  assign cwpDn        = cwp - CWP_W'(1);
  assign cwpUp        = cwp + CWP_W'(1);
  assign saveFault    = wimMask[cwpDn];
  assign restoreFault = wimMask[cwpUp];

  assign tbrOut  = {tbrBase, ttReg, 4'h0};
  assign vecAddr = svEnable ? {tbrBase, 12'h000} : tbrOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp     <= '0;
      et      <= 1'b0;
      sup     <= 1'b1;
      prevSup <= 1'b0;
      tbrBase <= '0;
      ttReg   <= '0;
      pc      <= '0;
      npc     <= XLEN'(4);
    end else begin
      if (strb.ldState) begin
        cwp     <= ctlCwp;
        et      <= ctlEt;
        sup     <= ctlS;
        prevSup <= ctlPs;
        tbrBase <= ctlTbrBase;
        pc      <= ctlPc;
        npc     <= ctlNpc;
      end
      if (strb.latchType) ttReg <= strb.trapType;
      if (strb.rotate) begin
        cwp     <= cwpDn;
        et      <= 1'b0;
        prevSup <= sup;
        sup     <= 1'b1;
      end
      if (strb.winSave)    cwp <= cwpDn;
      if (strb.winRestore) cwp <= cwpUp;
      if (strb.vector) begin
        pc  <= vecAddr;
        npc <= vecAddr + XLEN'(4);
      end
    end
  end

  assign regWrEn   = strb.savePc | strb.saveNpc;
  assign regWrWin  = cwp;
  assign regWrIdx  = strb.savePc ? PC_SLOT : NPC_SLOT;
  assign regWrData = strb.savePc ? pc : npc;

  assign pcOut   = pc;
  assign npcOut  = npc;
  assign cwpOut  = cwp;
  assign etOut   = et;
  assign sOut    = sup;
  assign psOut   = prevSup;

  // R7: the first save of a sequence targets the PC slot
  p_first_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regWrEn) |-> (regWrIdx == PC_SLOT)) else $error("first save not PC slot");
  // R7: the saves go to the window one below the one before rotation
  p_cwp_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regWrEn) |-> (regWrWin == $past(cwp) - CWP_W'(1))) else $error("window not rotated");
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NWIN = 8,
  localparam int CWP_W  = $clog2(NWIN),
  localparam int BASE_W = XLEN - 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        irqLevel,
  input  logic [3:0]        pilLevel,
  input  logic              trapReq,
  input  logic [7:0]        trapType,
  input  logic              winSaveReq,
  input  logic              winRestoreReq,
  input  logic [NWIN-1:0]   wimMask,
  input  logic              svEnable,
  input  logic              ctlWrEn,
  input  logic [CWP_W-1:0]  ctlCwp,
  input  logic              ctlEt,
  input  logic              ctlS,
  input  logic              ctlPs,
  input  logic [BASE_W-1:0] ctlTbrBase,
  input  logic [XLEN-1:0]   ctlPc,
  input  logic [XLEN-1:0]   ctlNpc,
  output logic              regWrEn,
  output logic [CWP_W-1:0]  regWrWin,
  output logic [4:0]        regWrIdx,
  output logic [XLEN-1:0]   regWrData,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   npcOut,
  output logic [XLEN-1:0]   tbrOut,
  output logic [CWP_W-1:0]  cwpOut,
  output logic              etOut,
  output logic              sOut,
  output logic              psOut,
  output logic              busy,
  output logic              errorMode
);
  strobe_t strb;
  logic    saveFault, restoreFault;

  trap_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqLevel(irqLevel), .pilLevel(pilLevel),
    .trapReq(trapReq), .trapType(trapType), .winSaveReq(winSaveReq),
    .winRestoreReq(winRestoreReq), .ctlWrEn(ctlWrEn), .etCur(etOut),
    .saveFault(saveFault), .restoreFault(restoreFault), .strb(strb),
    .busy(busy), .errorMode(errorMode)
  );

  trap_entry_dpath #(.XLEN(XLEN), .NWIN(NWIN)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wimMask(wimMask), .svEnable(svEnable),
    .ctlCwp(ctlCwp), .ctlEt(ctlEt), .ctlS(ctlS), .ctlPs(ctlPs),
    .ctlTbrBase(ctlTbrBase), .ctlPc(ctlPc), .ctlNpc(ctlNpc),
    .saveFault(saveFault), .restoreFault(restoreFault),
    .regWrEn(regWrEn), .regWrWin(regWrWin), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .pcOut(pcOut), .npcOut(npcOut), .tbrOut(tbrOut), .cwpOut(cwpOut),
    .etOut(etOut), .sOut(sOut), .psOut(psOut)
  );

  // R10: register writes only happen inside the busy window
  p_wr_in_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> busy) else $error("write outside busy");
  // R8: the vectored pair is consecutive
  p_vec_pair_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (npcOut == pcOut + XLEN'(4))) else $error("nPC not PC+4");
  // R8: single-vector target is 4 KiB aligned
  p_vec_align_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(svEnable)) |-> (pcOut[11:0] == 12'h000)) else $error("single vector misaligned");
  // R4: state frozen in error mode
  p_err_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    errorMode |=> ($stable(cwpOut) && $stable(pcOut) && $stable(etOut))) else $error("state moved in error mode");
endmodule

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rstN;
  logic [3:0]  bIrq, bPil;
  logic        bTrap, bSave, bRest, bSv, bCtl;
  logic [7:0]  bTt, bWim;
  logic [2:0]  cCwp;
  logic        cEt, cS, cPs;
  logic [19:0] cBase;
  logic [31:0] cPc, cNpc;

  logic        regWrEn, etOut, sOut, psOut, busy, errorMode;
  logic [2:0]  regWrWin, cwpOut;
  logic [4:0]  regWrIdx;
  logic [31:0] regWrData, pcOut, npcOut, tbrOut;

  trap_entry_unit u_trap_entry_unit (
    .clk(clk), .rstN(rstN), .irqLevel(bIrq), .pilLevel(bPil), .trapReq(bTrap),
    .trapType(bTt), .winSaveReq(bSave), .winRestoreReq(bRest), .wimMask(bWim),
    .svEnable(bSv), .ctlWrEn(bCtl), .ctlCwp(cCwp), .ctlEt(cEt), .ctlS(cS), .ctlPs(cPs),
    .ctlTbrBase(cBase), .ctlPc(cPc), .ctlNpc(cNpc),
    .regWrEn(regWrEn), .regWrWin(regWrWin), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .pcOut(pcOut), .npcOut(npcOut), .tbrOut(tbrOut), .cwpOut(cwpOut),
    .etOut(etOut), .sOut(sOut), .psOut(psOut), .busy(busy), .errorMode(errorMode)
  );

  // bench model of the architectural state
  logic [2:0]  mCwp;
  logic        mEt, mS, mPs, mErr;
  logic [19:0] mBase;
  logic [7:0]  mTt;
  logic [31:0] mPc, mNpc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit irqAccept(input logic [3:0] lvl, input logic [3:0] pil, input logic et);
    return (lvl != 4'h0) && et && ((lvl == 4'hF) || (lvl > pil));
  endfunction

  function automatic logic [31:0] vecOf(input logic sv, input logic [19:0] base, input logic [7:0] tt);
    return sv ? {base, 12'h000} : {base, tt, 4'h0};
  endfunction

  task automatic clearIn();
    bCtl = 0; bTrap = 0; bSave = 0; bRest = 0; bIrq = 0;
  endtask

  task automatic checkState(input string req);
    check(cwpOut == mCwp, {req, " cwp"}, 32'(cwpOut), 32'(mCwp));
    check(etOut == mEt, {req, " et"}, 32'(etOut), 32'(mEt));
    check(sOut == mS && psOut == mPs, {req, " s/ps"}, {30'h0, sOut, psOut}, {30'h0, mS, mPs});
    check(tbrOut == {mBase, mTt, 4'h0}, {req, " tbr"}, tbrOut, {mBase, mTt, 4'h0});
    check(pcOut == mPc && npcOut == mNpc, {req, " pc"}, pcOut ^ npcOut, mPc ^ mNpc);
    check(busy == 1'b0 && errorMode == mErr, {req, " busy/err"}, {30'h0, busy, errorMode}, {30'h0, 1'b0, mErr});
  endtask

  task automatic doReset();
    rstN = 0; clearIn();
    bPil = 0; bWim = 0; bSv = 0; bTt = 0;
    cCwp = 0; cEt = 0; cS = 0; cPs = 0; cBase = 0; cPc = 0; cNpc = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    mCwp = 0; mEt = 0; mS = 1; mPs = 0; mErr = 0; mBase = 0; mTt = 0; mPc = 0; mNpc = 32'd4;
  endtask

  // one decision cycle: inputs are already on the pins
  task automatic runCycle();
    int kind = 0;
    logic [7:0] tt = 8'h00;
    logic [2:0] dn = mCwp - 3'd1;
    logic [2:0] up = mCwp + 3'd1;
    logic [31:0] vec;
    if (mErr)                kind = 0;
    else if (bCtl)           kind = 1;
    else if (bTrap) begin    kind = 2; tt = bTt; end
    else if (bSave) begin
      if (bWim[dn]) begin kind = 2; tt = 8'h05; end else kind = 3;
    end else if (bRest) begin
      if (bWim[up]) begin kind = 2; tt = 8'h06; end else kind = 4;
    end else if (irqAccept(bIrq, bPil, mEt)) begin kind = 2; tt = 8'h10 + {4'h0, bIrq}; end
    @(posedge clk); @(negedge clk);
    case (kind)
      1: begin
        mCwp = cCwp; mEt = cEt; mS = cS; mPs = cPs; mBase = cBase; mPc = cPc; mNpc = cNpc;
        clearIn(); checkState("R11");
      end
      3: begin mCwp = dn; clearIn(); checkState("R9 save"); end
      4: begin mCwp = up; clearIn(); checkState("R9 restore"); end
      2: begin
        if (!mEt) begin
          mErr = 1; clearIn();
          checkState("R4");
        end else begin
          check(busy == 1'b1, "R10 busy", 32'(busy), 32'd1);
          // requests held during busy must be ignored
          bTrap = 1; bTt = 8'h77; bIrq = 4'hF; bCtl = 1; bSave = 1;
          @(negedge clk);
          check(regWrEn && regWrIdx == 5'd17 && regWrWin == dn, "R7 pc slot",
                {regWrEn, 23'h0, regWrWin, regWrIdx}, {1'b1, 23'h0, dn, 5'd17});
          check(regWrData == mPc, "R7 pc data", regWrData, mPc);
          @(negedge clk);
          check(regWrEn && regWrIdx == 5'd18 && regWrWin == dn, "R7 npc slot",
                {regWrEn, 23'h0, regWrWin, regWrIdx}, {1'b1, 23'h0, dn, 5'd18});
          check(regWrData == mNpc, "R7 npc data", regWrData, mNpc);
          @(negedge clk);
          check(!regWrEn && busy, "R10 vector cycle", {30'h0, regWrEn, busy}, 32'd1);
          @(negedge clk);
          clearIn();
          vec = vecOf(bSv, mBase, tt);
          mTt = tt; mPs = mS; mS = 1; mEt = 0; mCwp = dn; mPc = vec; mNpc = vec + 32'd4;
          checkState("R5/R6/R8/R10");
        end
      end
      default: begin clearIn(); checkState(mErr ? "R4 frozen" : "R2/R3 idle"); end
    endcase
  endtask

  task automatic load(input logic [2:0] cw, input logic et, input logic s, input logic ps,
                      input logic [19:0] base, input logic [31:0] pc);
    cCwp = cw; cEt = et; cS = s; cPs = ps; cBase = base; cPc = pc; cNpc = pc + 32'd4;
    bCtl = 1;
    runCycle();
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    doReset();
    @(negedge clk);
    checkState("R1");

    load(3'd0, 1, 0, 1, 20'hABCDE, 32'h0000_0100);
    // R2: level equal to mask is refused, one above is taken; cwp wraps 0 -> 7 (R7)
    bIrq = 4'd5; bPil = 4'd5; runCycle();
    bIrq = 4'd6; bPil = 4'd5; runCycle();
    // R2: level 15 beats mask 15
    load(3'd4, 1, 1, 0, 20'h12345, 32'h0000_2000);
    bIrq = 4'hF; bPil = 4'hF; runCycle();
    // R2: level 0 never taken
    load(3'd4, 1, 0, 0, 20'h12345, 32'h0000_2000);
    bIrq = 4'h0; bPil = 4'h0; runCycle();
    // R3: sync trap beats save and interrupt
    bTrap = 1; bTt = 8'h2A; bSave = 1; bIrq = 4'hF; runCycle();
    // R9: save fault, restore fault, plain moves and wrap 7 -> 0
    load(3'd3, 1, 1, 1, 20'h00F00, 32'h0000_0040);
    bWim = 8'h04; bSave = 1; runCycle();
    load(3'd3, 1, 1, 1, 20'h00F00, 32'h0000_0040);
    bWim = 8'h10; bRest = 1; runCycle();
    load(3'd3, 1, 1, 1, 20'h00F00, 32'h0000_0040);
    bWim = 8'h00; bSave = 1; runCycle();
    bRest = 1; runCycle();
    load(3'd7, 1, 1, 1, 20'h00F00, 32'h0000_0040);
    bRest = 1; runCycle();
    // R3: save beats restore and interrupt
    bSave = 1; bRest = 1; bIrq = 4'hF; runCycle();
    // R8: single-vector mode
    load(3'd2, 1, 0, 0, 20'hFEDCB, 32'h0000_3000);
    bSv = 1; bTrap = 1; bTt = 8'h9C; runCycle();
    bSv = 0;
    // R4: trap with ET=0 enters error mode, later load ignored
    load(3'd5, 0, 1, 0, 20'h00001, 32'h0000_0500);
    bTrap = 1; bTt = 8'h01; runCycle();
    cCwp = 3'd1; cEt = 1; bCtl = 1; runCycle();
    bSave = 1; runCycle();
    doReset();
    @(negedge clk);
    checkState("R1 again");

    for (int i = 0; i < 400; i++) begin
      if (mErr) begin doReset(); @(negedge clk); end
      if ($urandom % 4 == 0) begin
        load(3'($urandom), ($urandom % 5) != 0, 1'($urandom), 1'($urandom),
             20'($urandom), $urandom);
      end else begin
        bTrap = ($urandom % 6) == 0; bTt = 8'($urandom);
        bSave = ($urandom % 4) == 0; bRest = ($urandom % 4) == 0;
        bIrq = 4'($urandom); bPil = 4'($urandom);
        bWim = 8'($urandom); bSv = 1'($urandom);
        runCycle();
      end
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule